// File: doc/BRIEF.md
# Event Counter Unit

This block is a memory-mapped performance monitor with eight 64-bit event counters. Each counter watches one of 256 event lines, chosen by an 8-bit event code. Line 0 is not a pin. It is tied high inside the block, so code 0x00 counts clock cycles. Lines 1 to 255 are single-cycle pulse inputs from the monitored logic. A counter advances only when three things are all set: the global run bit, its own enable bit, and a power-management override bit. When a counter wraps past all-ones, it sets a sticky overflow flag. That flag can raise an interrupt unless its mask bit blocks it. Software clears a flag by writing a one to its bit in the clear register.

Software reaches the unit over a simple request/response bus that carries 16-bit byte offsets and 64-bit data, with a flag that selects 32-bit or 64-bit access. A small state machine runs the bus and has two states:
- `BUS_IDLE` accepts any request. A write takes effect at the accepting edge and the machine stays in `BUS_IDLE`. A read is captured at that edge, which is the transition "read accept" to `BUS_RESP`.
- `BUS_RESP` presents the read data for exactly one cycle, with the request side stalled. It then takes the transition "response delivered" back to `BUS_IDLE`.

Register map (offsets in hex):
- 0534: bit 9 is the power-management override.
- 1C00: bit 0 is the global run bit.
- 1C04: per-counter enables.
- 1C70: interrupt mask.
- 1C78: overflow status, read-only.
- 1C7C: overflow clear, write-one; reads as 0.
- 1C80 and 1C84: event select.
- 1CF0: version.
- 1D00 + 8·n: counter n.

Top module: `evt_counter_unit`

## Requirements
- R1: After reset, every counter, enable, event code, overflow flag, the run bit and the override bit read as 0, the mask reads 0xFF, and `irq` is low.
- R2: Counter n takes its code from the select register at 0x1C80 (n = 0..3) or 0x1C84 (n = 4..7), in bits [8·(n mod 4)+7 : 8·(n mod 4)]. It counts one per pulse on the event line with that number, and pulses on other lines leave it unchanged. The select registers read back as written.
- R3: A counter holds its value whenever any one of these is 0: bit 0 at 0x1C00, its bit n at 0x1C04, or bit 9 at 0x0534.
- R4: Code 0x00 counts every clock edge at which the counter is enabled. Setting the run bit at edge E1 and clearing it at edge E2 adds E2−E1.
- R5: A 64-bit access to 0x1D00+8·n reads or writes the whole counter. A 32-bit access reads or writes the low half at +0 and the high half at +4, leaving the other half unchanged.
- R6: A software write to a counter wins over an increment in the same cycle. The counter then holds exactly the written value.
- R7: An increment from all-ones wraps the counter to 0 and sets overflow status bit n, read at 0x1C78.
- R8: `irq` is high exactly when some status bit is set whose mask bit at 0x1C70 is 0. A mask bit of 1 blocks that counter.
- R9: Writing to 0x1C7C clears each status bit whose written bit is 1. Zero bits in the write leave the status unchanged.
- R10: If a wrap and a clear of the same status bit fall in one cycle, the bit ends set.
- R11: Read data appears with `rsp_valid` one cycle after the read is accepted. `req_ready` is low during that response cycle. Unmapped offsets read as 0.
- R12: Offset 0x1CF0 returns the version parameter, which defaults to 0x00000031.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_addr | input | 16 | Byte offset within the unit |
| req_wdata | input | 64 | Write data (32-bit accesses use bits 31:0) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| evt_in | input | 255 | Event pulse lines 255 down to 1 |
| irq | output | 1 | Overflow interrupt |

## Verification
Two pairs of actions can land on the same clock edge.

The first pair is a software counter write and an increment. To provoke it, the bench holds an event line high across the write edge. It then expects exactly the written value back, with no extra count.

The second pair is an overflow wrap and a write-one clear of that same status bit. To provoke it, the bench loads all-ones into a counter whose event line stays high. It then issues the clear on the very next edge, which is the edge of the wrap. The status bit must still read as set, and the counter must read 0.

// File: rtl/evtc_pkg.sv
package evtc_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 64;
    localparam int PM_BIT = 9;

    localparam logic [ADDR_W-1:0] A_CFG      = 16'h0534;
    localparam logic [ADDR_W-1:0] A_RUN      = 16'h1C00;
    localparam logic [ADDR_W-1:0] A_ENABLE   = 16'h1C04;
    localparam logic [ADDR_W-1:0] A_MASK     = 16'h1C70;
    localparam logic [ADDR_W-1:0] A_STATUS   = 16'h1C78;
    localparam logic [ADDR_W-1:0] A_CLEAR    = 16'h1C7C;
    localparam logic [ADDR_W-1:0] A_SEL_BASE = 16'h1C80;
    localparam logic [ADDR_W-1:0] A_VERSION  = 16'h1CF0;
    localparam logic [ADDR_W-1:0] A_CNT_BASE = 16'h1D00;

    typedef enum logic {
        BUS_IDLE,
        BUS_RESP
    } bus_state_e;

endpackage

// File: rtl/evtc_bus_fsm.sv
module evtc_bus_fsm
    import evtc_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid_i,
    input  logic          req_write_i,
    input  logic [DW-1:0] rd_value_i,
    output logic          req_ready_o,
    output logic          wr_accept_o,
    output logic          rd_accept_o,
    output logic          rsp_valid_o,
    output logic [DW-1:0] rsp_rdata_o
);

    bus_state_e state_q, state_d;
    logic [DW-1:0] rdata_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: read accept (IDLE->RESP), response delivered (RESP->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: begin
                if (req_valid_i && !req_write_i) begin
                    state_d = BUS_RESP;
                end
            end
            BUS_RESP: begin
                state_d = BUS_IDLE;
            end
            default: begin
                state_d = BUS_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        req_ready_o = 1'b0;
        rsp_valid_o = 1'b0;
        unique case (state_q)
            BUS_IDLE: req_ready_o = 1'b1;
            BUS_RESP: rsp_valid_o = 1'b1;
            default: begin
                req_ready_o = 1'b0;
                rsp_valid_o = 1'b0;
            end
        endcase
        wr_accept_o = req_ready_o && req_valid_i && req_write_i;
        rd_accept_o = req_ready_o && req_valid_i && !req_write_i;
        rsp_rdata_o = rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_accept_o) begin
            rdata_q <= rd_value_i;
        end
    end

endmodule

// File: rtl/evtc_counter_slice.sv
module evtc_counter_slice #(
    parameter int CNT_W   = 64,
    parameter int CODE_W  = 8,
    parameter int NUM_EVT = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gate_i,
    input  logic [CODE_W-1:0]  code_i,
    input  logic [NUM_EVT-1:0] evt_vec_i,
    input  logic               wr_lo_i,
    input  logic               wr_hi_i,
    input  logic [CNT_W/2-1:0] wdata_lo_i,
    input  logic [CNT_W/2-1:0] wdata_hi_i,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               wrap_o
);

    localparam int HALF_W = CNT_W / 2;

    logic [CNT_W-1:0] cnt_q;
    logic             hit;
    logic             sw_write;

    always_comb begin
        hit      = gate_i && evt_vec_i[code_i];
        sw_write = wr_lo_i || wr_hi_i;
        wrap_o   = hit && !sw_write && (&cnt_q);
        cnt_o    = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (sw_write) begin
            cnt_q <= {wr_hi_i ? wdata_hi_i : cnt_q[CNT_W-1:HALF_W],
                      wr_lo_i ? wdata_lo_i : cnt_q[HALF_W-1:0]};
        end else if (hit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/evtc_regfile.sv
module evtc_regfile
    import evtc_pkg::*;
#(
    parameter int          NUM_CNT = 8,
    parameter int          CNT_W   = 64,
    parameter int          CODE_W  = 8,
    parameter logic [31:0] VERSION = 32'h0000_0031
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_i,
    input  logic                      wide_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [DATA_W-1:0]         wdata_i,
    input  logic [NUM_CNT*CNT_W-1:0]  cnt_flat_i,
    input  logic [NUM_CNT-1:0]        wrap_i,
    output logic [DATA_W-1:0]         rd_value_o,
    output logic [NUM_CNT-1:0]        gate_o,
    output logic [NUM_CNT*CODE_W-1:0] code_flat_o,
    output logic [NUM_CNT-1:0]        cnt_wr_lo_o,
    output logic [NUM_CNT-1:0]        cnt_wr_hi_o,
    output logic [CNT_W/2-1:0]        cnt_wdata_lo_o,
    output logic [CNT_W/2-1:0]        cnt_wdata_hi_o,
    output logic [NUM_CNT-1:0]        mask_o,
    output logic [NUM_CNT-1:0]        status_o,
    output logic                      pm_o,
    output logic                      irq_o
);

    localparam int HALF_W = CNT_W / 2;
    localparam int PER_SEL = 4;
    localparam logic [ADDR_W-1:0] CNT_SPAN = ADDR_W'(8 * NUM_CNT);

    logic                run_q;
    logic                pm_q;
    logic [NUM_CNT-1:0]  en_q;
    logic [NUM_CNT-1:0]  mask_q;
    logic [NUM_CNT-1:0]  status_q;
    logic [CODE_W-1:0]   code_q [NUM_CNT];

    logic                aligned;
    logic [ADDR_W-1:0]   cnt_off;
    logic                hit_cnt;
    logic [NUM_CNT-1:0]  cnt_sel;
    logic [NUM_CNT-1:0]  clr_bits;

    // address decode
    always_comb begin
        aligned = (addr_i[1:0] == 2'b00);
        cnt_off = addr_i - A_CNT_BASE;
        hit_cnt = aligned && (addr_i >= A_CNT_BASE) && (cnt_off < CNT_SPAN);
        for (int n = 0; n < NUM_CNT; n++) begin
            cnt_sel[n] = hit_cnt && (cnt_off[ADDR_W-1:3] == (ADDR_W-3)'(n));
        end
    end

    // counter write strobes
    always_comb begin
        for (int n = 0; n < NUM_CNT; n++) begin
            cnt_wr_lo_o[n] = wr_i && cnt_sel[n] && (wide_i || !cnt_off[2]);
            cnt_wr_hi_o[n] = wr_i && cnt_sel[n] && (wide_i || cnt_off[2]);
        end
        cnt_wdata_lo_o = wdata_i[HALF_W-1:0];
        cnt_wdata_hi_o = wide_i ? wdata_i[CNT_W-1:HALF_W] : wdata_i[HALF_W-1:0];
    end

    // control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            pm_q   <= 1'b0;
            en_q   <= '0;
            mask_q <= '1;
            for (int n = 0; n < NUM_CNT; n++) begin
                code_q[n] <= '0;
            end
        end else if (wr_i) begin
            if (addr_i == A_RUN)    run_q  <= wdata_i[0];
            if (addr_i == A_CFG)    pm_q   <= wdata_i[PM_BIT];
            if (addr_i == A_ENABLE) en_q   <= wdata_i[NUM_CNT-1:0];
            if (addr_i == A_MASK)   mask_q <= wdata_i[NUM_CNT-1:0];
            for (int n = 0; n < NUM_CNT; n++) begin
                if (addr_i == (A_SEL_BASE + ADDR_W'(4 * (n / PER_SEL)))) begin
                    code_q[n] <= wdata_i[CODE_W*(n%PER_SEL) +: CODE_W];
                end
            end
        end
    end

    // sticky overflow status, a wrap beats a same-cycle clear
    always_comb begin
        clr_bits = (wr_i && addr_i == A_CLEAR) ? wdata_i[NUM_CNT-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_bits) | wrap_i;
        end
    end

    // read mux
    always_comb begin
        rd_value_o = '0;
        if (addr_i == A_RUN)     rd_value_o[0]              = run_q;
        if (addr_i == A_CFG)     rd_value_o[PM_BIT]         = pm_q;
        if (addr_i == A_ENABLE)  rd_value_o[NUM_CNT-1:0]    = en_q;
        if (addr_i == A_MASK)    rd_value_o[NUM_CNT-1:0]    = mask_q;
        if (addr_i == A_STATUS)  rd_value_o[NUM_CNT-1:0]    = status_q;
        if (addr_i == A_VERSION) rd_value_o[31:0]           = VERSION;
        for (int n = 0; n < NUM_CNT; n++) begin
            if (addr_i == (A_SEL_BASE + ADDR_W'(4 * (n / PER_SEL)))) begin
                rd_value_o[CODE_W*(n%PER_SEL) +: CODE_W] = code_q[n];
            end
            if (cnt_sel[n]) begin
                if (wide_i) begin
                    rd_value_o = cnt_flat_i[n*CNT_W +: CNT_W];
                end else if (cnt_off[2]) begin
                    rd_value_o = {{HALF_W{1'b0}}, cnt_flat_i[n*CNT_W+HALF_W +: HALF_W]};
                end else begin
                    rd_value_o = {{HALF_W{1'b0}}, cnt_flat_i[n*CNT_W +: HALF_W]};
                end
            end
        end
    end

    // outputs to the counters and interrupt
    always_comb begin
        for (int n = 0; n < NUM_CNT; n++) begin
            gate_o[n] = run_q && pm_q && en_q[n];
            code_flat_o[n*CODE_W +: CODE_W] = code_q[n];
        end
        mask_o   = mask_q;
        status_o = status_q;
        pm_o     = pm_q;
        irq_o    = |(status_q & ~mask_q);
    end

endmodule

// File: rtl/evt_counter_unit.sv
module evt_counter_unit
    import evtc_pkg::*;
#(
    parameter int          NUM_CNT = 8,
    parameter int          CNT_W   = 64,
    parameter int          CODE_W  = 8,
    parameter logic [31:0] VERSION = 32'h0000_0031
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic                   req_wide,
    input  logic [15:0]            req_addr,
    input  logic [63:0]            req_wdata,
    output logic                   rsp_valid,
    output logic [63:0]            rsp_rdata,
    input  logic [(1<<CODE_W)-1:1] evt_in,
    output logic                   irq
);

    localparam int NUM_EVT = 1 << CODE_W;
    localparam int HALF_W  = CNT_W / 2;

    logic                      wr_accept;
    logic                      rd_accept;
    logic [DATA_W-1:0]         rd_value;
    logic [NUM_EVT-1:0]        evt_vec;
    logic [NUM_CNT*CNT_W-1:0]  cnt_flat;
    logic [NUM_CNT-1:0]        wrap_w;
    logic [NUM_CNT-1:0]        gate_w;
    logic [NUM_CNT*CODE_W-1:0] code_flat;
    logic [NUM_CNT-1:0]        wr_lo_w;
    logic [NUM_CNT-1:0]        wr_hi_w;
    logic [HALF_W-1:0]         wdata_lo_w;
    logic [HALF_W-1:0]         wdata_hi_w;
    logic [NUM_CNT-1:0]        mask_w;
    logic [NUM_CNT-1:0]        status_w;
    logic                      pm_w;

    // line 0 is the always-on cycle source
    assign evt_vec = {evt_in, 1'b1};

    evtc_bus_fsm #(.DW(DATA_W)) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_write_i (req_write),
        .rd_value_i  (rd_value),
        .req_ready_o (req_ready),
        .wr_accept_o (wr_accept),
        .rd_accept_o (rd_accept),
        .rsp_valid_o (rsp_valid),
        .rsp_rdata_o (rsp_rdata)
    );

    evtc_regfile #(
        .NUM_CNT (NUM_CNT),
        .CNT_W   (CNT_W),
        .CODE_W  (CODE_W),
        .VERSION (VERSION)
    ) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_i           (wr_accept),
        .wide_i         (req_wide),
        .addr_i         (req_addr),
        .wdata_i        (req_wdata),
        .cnt_flat_i     (cnt_flat),
        .wrap_i         (wrap_w),
        .rd_value_o     (rd_value),
        .gate_o         (gate_w),
        .code_flat_o    (code_flat),
        .cnt_wr_lo_o    (wr_lo_w),
        .cnt_wr_hi_o    (wr_hi_w),
        .cnt_wdata_lo_o (wdata_lo_w),
        .cnt_wdata_hi_o (wdata_hi_w),
        .mask_o         (mask_w),
        .status_o       (status_w),
        .pm_o           (pm_w),
        .irq_o          (irq)
    );

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
        evtc_counter_slice #(
            .CNT_W   (CNT_W),
            .CODE_W  (CODE_W),
            .NUM_EVT (NUM_EVT)
        ) u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .gate_i     (gate_w[n]),
            .code_i     (code_flat[n*CODE_W +: CODE_W]),
            .evt_vec_i  (evt_vec),
            .wr_lo_i    (wr_lo_w[n]),
            .wr_hi_i    (wr_hi_w[n]),
            .wdata_lo_i (wdata_lo_w),
            .wdata_hi_i (wdata_hi_w),
            .cnt_o      (cnt_flat[n*CNT_W +: CNT_W]),
            .wrap_o     (wrap_w[n])
        );
    end

endmodule

// File: rtl/evtc_checker.sv
module evtc_checker #(
    parameter int NUM_CNT = 8,
    parameter int CNT_W   = 64
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic                     req_write,
    input logic                     req_ready,
    input logic                     rsp_valid,
    input logic                     irq,
    input logic [NUM_CNT-1:0]       mask,
    input logic [NUM_CNT-1:0]       status,
    input logic                     pm_ovr,
    input logic [NUM_CNT*CNT_W-1:0] cnt_flat
);

    logic bus_wr;
    assign bus_wr = req_valid && req_write && req_ready;

    assert_read_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_ready) |=> (rsp_valid && !req_ready));

    assert_single_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_pm_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pm_ovr && !bus_wr) |=> $stable(cnt_flat));

    assert_all_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1) |-> !irq);

    assert_irq_has_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));

    assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ((status & $past(status)) == $past(status)));

endmodule

bind evt_counter_unit evtc_checker #(
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .irq       (irq),
    .mask      (mask_w),
    .status    (status_w),
    .pm_ovr    (pm_w),
    .cnt_flat  (cnt_flat)
);

// File: tb/sim_evt_counter_unit.sv
module sim_evt_counter_unit;

    localparam logic [15:0] CFG = 16'h0534, RUN = 16'h1C00, ENA = 16'h1C04;
    localparam logic [15:0] MSK = 16'h1C70, STS = 16'h1C78, CLR = 16'h1C7C;
    localparam logic [15:0] SEL0 = 16'h1C80, SEL1 = 16'h1C84, VER = 16'h1CF0;
    localparam logic [15:0] CNT = 16'h1D00;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_wide, req_ready;
    logic [15:0] req_addr;
    logic [63:0] req_wdata, rsp_rdata;
    logic        rsp_valid, irq;
    logic [255:1] evt_in;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    evt_counter_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_wide(req_wide), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .evt_in(evt_in), .irq(irq)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [63:0] d, bit wide = 1'b0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_wide = wide;
        req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, bit wide, output logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_wide = wide; req_addr = a;
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk);
        d = rsp_rdata;
    endtask

    task automatic pulse(int line, int n);
        repeat (n) begin
            @(negedge clk); evt_in[line] = 1'b1;
            @(negedge clk); evt_in[line] = 1'b0;
        end
    endtask

    task automatic t_reset;
        logic [63:0] d;
        rd(MSK, 0, d);  check("R1 mask", d, 64'hFF);
        rd(STS, 0, d);  check("R1 status", d, 0);
        rd(RUN, 0, d);  check("R1 run", d, 0);
        rd(ENA, 0, d);  check("R1 enable", d, 0);
        rd(CFG, 0, d);  check("R1 override", d, 0);
        rd(SEL1, 0, d); check("R1 select", d, 0);
        rd(CNT + 16'd24, 1, d); check("R1 counter3", d, 0);
        check("R1 irq", {63'd0, irq}, 0);
        rd(VER, 0, d);  check("R12 version", d, 64'h31);
    endtask

    task automatic t_bus;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_wide = 1'b1; req_addr = 16'h1C08;
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk);
        check("R11 rsp_valid", {63'd0, rsp_valid}, 1);
        check("R11 ready low", {63'd0, req_ready}, 0);
        check("R11 unmapped", rsp_rdata, 0);
        @(negedge clk);
        check("R11 rsp_valid drop", {63'd0, rsp_valid}, 0);
    endtask

    task automatic t_select;
        logic [63:0] d;
        wr(CFG, 64'h200); wr(RUN, 1);
        wr(SEL0, 64'h1110_6261); wr(SEL1, 64'h2120_E2E1);
        wr(ENA, 64'hFF);
        pulse(8'h61, 3); pulse(8'hE2, 5); pulse(8'h20, 2);
        rd(CNT, 1, d);          check("R2 cnt0", d, 3);
        rd(CNT + 16'd8, 1, d);  check("R2 cnt1", d, 0);
        rd(CNT + 16'd32, 1, d); check("R2 cnt4", d, 0);
        rd(CNT + 16'd40, 1, d); check("R2 cnt5", d, 5);
        rd(CNT + 16'd48, 1, d); check("R2 cnt6", d, 2);
        rd(SEL1, 0, d);         check("R2 select readback", d, 64'h2120_E2E1);
    endtask

    task automatic t_gating;
        logic [63:0] d;
        wr(ENA, 64'hFE); pulse(8'h61, 2);
        rd(CNT, 1, d); check("R3 counter enable off", d, 3);
        wr(ENA, 64'hFF); wr(RUN, 0); pulse(8'h61, 2);
        rd(CNT, 1, d); check("R3 run off", d, 3);
        wr(RUN, 1); wr(CFG, 0); pulse(8'h61, 2);
        rd(CNT, 1, d); check("R3 override off", d, 3);
        wr(CFG, 64'h200); pulse(8'h61, 1);
        rd(CNT, 1, d); check("R3 all on", d, 4);
    endtask

    task automatic t_cycles;
        logic [63:0] d;
        wr(RUN, 0); wr(SEL1, 64'h0020_E2E1); wr(CNT + 16'd56, 0, 1);
        wr(RUN, 1);
        repeat (10) @(negedge clk);
        wr(RUN, 0);
        rd(CNT + 16'd56, 1, d); check("R4 cycle count", d, 11);
        wr(SEL1, 64'h2120_E2E1); wr(RUN, 1);
    endtask

    task automatic t_access;
        logic [63:0] d;
        wr(CNT + 16'd24, 64'h0123_4567_89AB_CDEF, 1);
        rd(CNT + 16'd24, 1, d); check("R5 wide read", d, 64'h0123_4567_89AB_CDEF);
        rd(CNT + 16'd24, 0, d); check("R5 low half", d, 64'h89AB_CDEF);
        rd(CNT + 16'd28, 0, d); check("R5 high half", d, 64'h0123_4567);
        wr(CNT + 16'd28, 64'hDEAD_BEEF, 0);
        rd(CNT + 16'd24, 1, d); check("R5 high write", d, 64'hDEAD_BEEF_89AB_CDEF);
        wr(CNT + 16'd24, 64'h11, 0);
        rd(CNT + 16'd24, 1, d); check("R5 low write", d, 64'hDEAD_BEEF_0000_0011);
    endtask

    task automatic t_priority;
        logic [63:0] d;
        @(negedge clk); evt_in[8'h20] = 1'b1;
        wr(CNT + 16'd48, 64'h500, 1);
        evt_in[8'h20] = 1'b0;
        rd(CNT + 16'd48, 1, d); check("R6 write wins", d, 64'h500);
    endtask

    task automatic t_overflow;
        logic [63:0] d;
        wr(CNT + 16'd8, ONES, 1); pulse(8'h62, 1);
        rd(CNT + 16'd8, 1, d); check("R7 wrap to zero", d, 0);
        rd(STS, 0, d);         check("R7 status set", d, 64'h02);
        check("R8 masked irq", {63'd0, irq}, 0);
        wr(MSK, 64'hFD); @(negedge clk);
        check("R8 unmasked irq", {63'd0, irq}, 1);
    endtask

    task automatic t_clear;
        logic [63:0] d;
        wr(CNT + 16'd8, ONES, 1); wr(CNT + 16'd32, ONES, 1);
        pulse(8'h62, 1); pulse(8'hE1, 1);
        rd(STS, 0, d); check("R7 two flags", d, 64'h12);
        wr(CLR, 0); rd(STS, 0, d); check("R9 zero write", d, 64'h12);
        wr(CLR, 64'h02); rd(STS, 0, d); check("R9 clear one bit", d, 64'h10);
        check("R8 masked remaining", {63'd0, irq}, 0);
        wr(CLR, 64'h10); rd(STS, 0, d); check("R9 clear all", d, 0);
    endtask

    task automatic t_same_cycle;
        logic [63:0] d;
        @(negedge clk); evt_in[8'h10] = 1'b1;
        wr(CNT + 16'd16, ONES, 1);
        wr(CLR, 64'h04);
        evt_in[8'h10] = 1'b0;
        rd(STS, 0, d);          check("R10 set beats clear", d, 64'h04);
        rd(CNT + 16'd16, 1, d); check("R10 counter wrapped", d, 0);
        wr(CLR, 64'h04); rd(STS, 0, d); check("R9 later clear", d, 0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_wide = 1'b0;
        req_addr = '0; req_wdata = '0; evt_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bus();
        t_select();
        t_gating();
        t_cycles();
        t_access();
        t_priority();
        t_overflow();
        t_clear();
        t_same_cycle();
        finish_run();
    end

endmodule